// File: doc/BRIEF.md
# Scan Chain Test Sequencer

This block pairs a small sequential circuit, whose state flops are mux-D scan cells, with a controller that tests the circuit through its scan chains. The state flops are split across several chains. A single test-control line sets the mode of every cell: when it is high the cells take their functional next state, and when it is low the cells shift. While a test runs, the low bits of the functional input bus carry the scan-in data and the low bits of the functional output bus carry the scan-out data. A mode multiplexer switches these pins back to functional use when no test is running.

A pulse on `start` begins a test of `n_vec` vectors. The controller first checks the chains by flushing a 0011 pattern through them. It then loads each vector's state pattern, holds test control high for one capture cycle while it applies the vector's inputs, and compares the outputs. The captured state is shifted out and compared while the next pattern shifts in. The vector source is a lookup indexed by `vec_idx`. Don't-care masks exclude unknown bits from comparison. A sticky fail flag and a one-cycle done pulse report the result.

Top module: `scan_test_seq`

## Requirements
- R1: During and after synchronous reset, `test_ctl` is 1, `test_done` and `test_fail` are 0, and every state flop holds 0.
- R2: When no test is running, the circuit uses `func_pi` and `func_po` directly and updates each cycle. Next state bit i is state[(i-1) mod NS] XOR pi[i mod PI_W]. Output bit j is state[NS-1-j] XOR pi[j].
- R3: Let SEG = ceil(NS/NCH). Chain c holds state bits c*SEG upward, and has Lc bits, where Lc is the smaller of SEG and the bits that remain. While `test_ctl` is 0, the cell holding the highest bit of chain c takes scan-in from input pin c, each other cell takes the bit above it, and `func_po[c]` shows the lowest bit of chain c. All `func_po` bits at or above NCH read 0.
- R4: The cycle after `start` is accepted begins a flush of SEG+4 cycles with `test_ctl` 0. In flush cycle k, every chain receives bit 1 of k (0,0,1,1,...). Each scan-out bit from flush cycle Lc onward is compared with the bit fed Lc cycles earlier.
- R5: A vector is loaded over SEG shift cycles. Chain c receives SEG-Lc leading zero filler bits, then its state bits from the lowest bit upward.
- R6: Each vector gets exactly one capture cycle with `test_ctl` 1. In that cycle the circuit inputs equal `vec_pi`, and `func_po` is compared with `vec_po_exp` wherever `vec_po_x` is 0.
- R7: The captured state shifts out during the next shift phase, at the same time as the next load. Bit j of chain c appears in shift cycle j and is compared with `vec_ns_exp` unless `vec_ns_x` marks it. After the last vector, one extra unload phase loads zeros.
- R8: `test_done` is a single-cycle pulse in cycle (SEG+4)+(SEG+1)·n_vec+SEG+1, counted from the cycle in which `start` was sampled. During the pulse `test_ctl` is 1 and the pins are back in functional mode.
- R9: `test_fail` is cleared when a test starts and set by any unmasked mismatch. It then holds until the next start.
- R10: `vec_idx` is the index of the vector being loaded and captured. It is 0 at start and steps by one after each capture. The vector inputs are read without a handshake.
- R11: A `start` pulse that arrives while a test is running has no effect.
- R12: With `n_vec` 0, the test runs the flush and one zero-load shift phase, then ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test |
| n_vec | input | VIDX_W | Number of vectors in the test |
| func_pi | input | PI_W | Functional inputs; the low NCH bits double as scan-in |
| func_po | output | PO_W | Functional outputs; the low NCH bits double as scan-out |
| test_ctl | output | 1 | 1 = normal/capture, 0 = shift |
| vec_idx | output | VIDX_W | Index of the requested vector |
| vec_pi | input | PI_W | Inputs applied in the capture cycle |
| vec_state | input | NS | State pattern to load |
| vec_po_exp | input | PO_W | Expected outputs in the capture cycle |
| vec_po_x | input | PO_W | Don't-care mask for the outputs (1 = ignore) |
| vec_ns_exp | input | NS | Expected captured next state |
| vec_ns_x | input | NS | Don't-care mask for the next state (1 = ignore) |
| test_done | output | 1 | One-cycle end-of-test pulse |
| test_fail | output | 1 | Sticky mismatch flag |

## Verification
The bench predicts every output bit cycle by cycle. It checks the flush stream, the filler on the short chain, and the unload that overlaps the next load. A design that put the filler at the wrong end, or shifted the wrong way, would emit the wrong scan-out bits. A design that lost one cycle of overlap would move the done pulse.

Planted corruptions of the expected next state and the expected outputs must raise the fail flag. The same corruptions, once masked, must not. A design that ignores the masks or fails to clear the flag at start would report stale results. A run with no vectors and a second start pulse in mid-test check the counting edge cases.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FLUSH,
        PH_SHIFT,
        PH_CAPT,
        PH_DONE
    } phase_t;

    // length of the longest chain
    function automatic int seg_len(input int ns, input int nch);
        return (ns + nch - 1) / nch;
    endfunction

    // length of chain c; trailing chains may be short
    function automatic int chain_len(input int ns, input int nch, input int c);
        int r;
        r = ns - c * seg_len(ns, nch);
        if (r > seg_len(ns, nch)) r = seg_len(ns, nch);
        if (r < 0) r = 0;
        return r;
    endfunction

endpackage

// File: rtl/scan_cut.sv
module scan_cut
    import scan_seq_pkg::*;
#(
    parameter int PI_W = 4,
    parameter int PO_W = 3,
    parameter int NS   = 5,
    parameter int NCH  = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tc,
    input  logic [PI_W-1:0] pi,
    input  logic [NCH-1:0]  sin,
    output logic [PO_W-1:0] po,
    output logic [NCH-1:0]  sout
);
    localparam int SEG = seg_len(NS, NCH);

    logic [NS-1:0] st;
    logic [NS-1:0] fnext;
    logic [NS-1:0] snext;

    for (genvar i = 0; i < NS; i++) begin : g_cell
        localparam int C  = i / SEG;
        localparam int J  = i % SEG;
        localparam int LC = chain_len(NS, NCH, C);
        assign fnext[i] = st[(i + NS - 1) % NS] ^ pi[i % PI_W];
        if (J == LC - 1) begin : g_head
            assign snext[i] = sin[C];
        end else begin : g_body
            assign snext[i] = st[i + 1];
        end
    end

    for (genvar j = 0; j < PO_W; j++) begin : g_po
        assign po[j] = st[NS - 1 - j] ^ pi[j];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_out
        assign sout[c] = st[c * SEG];
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= tc ? fnext : snext;
    end

endmodule

// File: rtl/scan_pin_mux.sv
module scan_pin_mux #(
    parameter int PI_W = 4,
    parameter int PO_W = 3,
    parameter int NCH  = 2
) (
    input  logic            scan_mode,
    input  logic            tc,
    input  logic [PI_W-1:0] func_pi,
    input  logic [PI_W-1:0] drive,
    input  logic [PO_W-1:0] cut_po,
    input  logic [NCH-1:0]  sout,
    output logic [PI_W-1:0] cut_pi,
    output logic [NCH-1:0]  sin,
    output logic [PO_W-1:0] func_po
);
    assign cut_pi = scan_mode ? drive : func_pi;
    assign sin    = cut_pi[NCH-1:0];

    always_comb begin
        func_po = '0;
        if (tc) func_po = cut_po;
        else    func_po[NCH-1:0] = sout;
    end

endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
    import scan_seq_pkg::*;
#(
    parameter int PI_W   = 4,
    parameter int PO_W   = 3,
    parameter int NS     = 5,
    parameter int NCH    = 2,
    parameter int VIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [VIDX_W-1:0] n_vec,
    input  logic [PI_W-1:0]   vec_pi,
    input  logic [NS-1:0]     vec_state,
    input  logic [PO_W-1:0]   vec_po_exp,
    input  logic [PO_W-1:0]   vec_po_x,
    input  logic [NS-1:0]     vec_ns_exp,
    input  logic [NS-1:0]     vec_ns_x,
    input  logic [PO_W-1:0]   obs,
    output logic              tc,
    output logic              scan_mode,
    output logic [PI_W-1:0]   drive,
    output logic [VIDX_W-1:0] vec_idx,
    output logic              done,
    output logic              fail
);
    localparam int SEG = seg_len(NS, NCH);
    localparam int CW  = $clog2(SEG + 5);

    phase_t            phase;
    logic [CW-1:0]     cnt;
    logic [VIDX_W-1:0] idx;
    logic [VIDX_W-1:0] nv;
    logic [NS-1:0]     unl_exp;
    logic [NS-1:0]     unl_x;
    logic              unl_valid;
    logic              fail_q;
    logic              load_ok;
    logic              mism;

    assign load_ok = (idx < nv);

    always_comb begin
        drive = '0;
        mism  = 1'b0;
        case (phase)
            PH_FLUSH: begin
                for (int c = 0; c < NCH; c++) begin
                    logic [CW-1:0] d;
                    drive[c] = cnt[1];
                    d = cnt - CW'(chain_len(NS, NCH, c));
                    if (cnt >= CW'(chain_len(NS, NCH, c)) && obs[c] != d[1])
                        mism = 1'b1;
                end
            end
            PH_SHIFT: begin
                for (int i = 0; i < NS; i++) begin
                    if (load_ok &&
                        cnt == CW'(SEG - chain_len(NS, NCH, i / SEG) + i % SEG))
                        drive[i / SEG] = vec_state[i];
                    if (unl_valid && cnt == CW'(i % SEG) && !unl_x[i] &&
                        obs[i / SEG] != unl_exp[i])
                        mism = 1'b1;
                end
            end
            PH_CAPT: begin
                drive = vec_pi;
                mism  = |((obs ^ vec_po_exp) & ~vec_po_x);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            idx       <= '0;
            nv        <= '0;
            unl_exp   <= '0;
            unl_x     <= '0;
            unl_valid <= 1'b0;
            fail_q    <= 1'b0;
        end else begin
            if (phase inside {PH_FLUSH, PH_SHIFT, PH_CAPT} && mism)
                fail_q <= 1'b1;
            case (phase)
                PH_IDLE: if (start) begin
                    phase     <= PH_FLUSH;
                    cnt       <= '0;
                    idx       <= '0;
                    nv        <= n_vec;
                    unl_valid <= 1'b0;
                    fail_q    <= 1'b0;
                end
                PH_FLUSH: begin
                    if (cnt == CW'(SEG + 3)) begin
                        phase <= PH_SHIFT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_SHIFT: begin
                    if (cnt == CW'(SEG - 1)) begin
                        cnt   <= '0;
                        phase <= load_ok ? PH_CAPT : PH_DONE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_CAPT: begin
                    unl_exp   <= vec_ns_exp;
                    unl_x     <= vec_ns_x;
                    unl_valid <= 1'b1;
                    idx       <= idx + 1'b1;
                    phase     <= PH_SHIFT;
                end
                PH_DONE: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign tc        = !(phase == PH_FLUSH || phase == PH_SHIFT);
    assign scan_mode = (phase == PH_FLUSH || phase == PH_SHIFT || phase == PH_CAPT);
    assign done      = (phase == PH_DONE);
    assign vec_idx   = idx;
    assign fail      = fail_q;

endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq
    import scan_seq_pkg::*;
#(
    parameter int PI_W   = 4,
    parameter int PO_W   = 3,
    parameter int NS     = 5,
    parameter int NCH    = 2,
    parameter int VIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [VIDX_W-1:0] n_vec,
    input  logic [PI_W-1:0]   func_pi,
    output logic [PO_W-1:0]   func_po,
    output logic              test_ctl,
    output logic [VIDX_W-1:0] vec_idx,
    input  logic [PI_W-1:0]   vec_pi,
    input  logic [NS-1:0]     vec_state,
    input  logic [PO_W-1:0]   vec_po_exp,
    input  logic [PO_W-1:0]   vec_po_x,
    input  logic [NS-1:0]     vec_ns_exp,
    input  logic [NS-1:0]     vec_ns_x,
    output logic              test_done,
    output logic              test_fail
);
    logic            scan_mode;
    logic [PI_W-1:0] drive;
    logic [PI_W-1:0] cut_pi;
    logic [NCH-1:0]  sin;
    logic [NCH-1:0]  sout;
    logic [PO_W-1:0] cut_po;

    scan_seq_ctrl #(
        .PI_W(PI_W), .PO_W(PO_W), .NS(NS), .NCH(NCH), .VIDX_W(VIDX_W)
    ) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .n_vec      (n_vec),
        .vec_pi     (vec_pi),
        .vec_state  (vec_state),
        .vec_po_exp (vec_po_exp),
        .vec_po_x   (vec_po_x),
        .vec_ns_exp (vec_ns_exp),
        .vec_ns_x   (vec_ns_x),
        .obs        (func_po),
        .tc         (test_ctl),
        .scan_mode  (scan_mode),
        .drive      (drive),
        .vec_idx    (vec_idx),
        .done       (test_done),
        .fail       (test_fail)
    );

    scan_pin_mux #(.PI_W(PI_W), .PO_W(PO_W), .NCH(NCH)) mux_i (
        .scan_mode (scan_mode),
        .tc        (test_ctl),
        .func_pi   (func_pi),
        .drive     (drive),
        .cut_po    (cut_po),
        .sout      (sout),
        .cut_pi    (cut_pi),
        .sin       (sin),
        .func_po   (func_po)
    );

    scan_cut #(.PI_W(PI_W), .PO_W(PO_W), .NS(NS), .NCH(NCH)) cut_i (
        .clk  (clk),
        .rst  (rst),
        .tc   (test_ctl),
        .pi   (cut_pi),
        .sin  (sin),
        .po   (cut_po),
        .sout (sout)
    );

endmodule

// File: rtl/scan_test_seq_chk.sv
module scan_test_seq_chk #(
    parameter int PO_W   = 3,
    parameter int NCH    = 2,
    parameter int VIDX_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              scan_mode,
    input logic              test_ctl,
    input logic              test_done,
    input logic              test_fail,
    input logic [VIDX_W-1:0] vec_idx,
    input logic [PO_W-1:0]   func_po
);
    p_idle_normal_r1: assert property (@(posedge clk) disable iff (rst)
        !scan_mode |-> test_ctl);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        test_done |=> !test_done);

    p_done_normal_r8: assert property (@(posedge clk) disable iff (rst)
        test_done |-> (test_ctl && !scan_mode));

    p_capt_single_r6: assert property (@(posedge clk) disable iff (rst)
        (scan_mode && test_ctl) |=> !test_ctl);

    p_fail_rise_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(test_fail) |-> $past(scan_mode));

    p_fail_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!scan_mode && !start) |=> $stable(test_fail));

    p_idx_step_r10: assert property (@(posedge clk) disable iff (rst)
        (vec_idx != $past(vec_idx)) |->
            (vec_idx == VIDX_W'($past(vec_idx) + 1'b1) || vec_idx == '0));

    if (PO_W > NCH) begin : g_hi
        p_shift_hi_zero_r3: assert property (@(posedge clk) disable iff (rst)
            !test_ctl |-> (func_po[PO_W-1:NCH] == '0));
    end

endmodule

bind scan_test_seq scan_test_seq_chk #(.PO_W(PO_W), .NCH(NCH), .VIDX_W(VIDX_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .scan_mode (scan_mode),
    .test_ctl  (test_ctl),
    .test_done (test_done),
    .test_fail (test_fail),
    .vec_idx   (vec_idx),
    .func_po   (func_po)
);

// File: tb/scan_test_seq_tb_top.sv
module scan_test_seq_tb_top;
    import scan_seq_pkg::*;

    localparam int PI_W   = 4;
    localparam int PO_W   = 3;
    localparam int NS     = 5;
    localparam int NCH    = 2;
    localparam int VIDX_W = 4;
    localparam int SEG    = seg_len(NS, NCH);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [VIDX_W-1:0] n_vec = '0;
    logic [PI_W-1:0]   func_pi = '0;
    logic [PO_W-1:0]   func_po;
    logic              test_ctl;
    logic [VIDX_W-1:0] vec_idx;
    logic [PI_W-1:0]   vec_pi;
    logic [NS-1:0]     vec_state;
    logic [PO_W-1:0]   vec_po_exp;
    logic [PO_W-1:0]   vec_po_x;
    logic [NS-1:0]     vec_ns_exp;
    logic [NS-1:0]     vec_ns_x;
    logic              test_done;
    logic              test_fail;

    logic [PI_W-1:0] vpi  [16];
    logic [NS-1:0]   vst  [16];
    logic [PO_W-1:0] vpo  [16];
    logic [PO_W-1:0] vpox [16];
    logic [NS-1:0]   vns  [16];
    logic [NS-1:0]   vnsx [16];

    assign vec_pi     = vpi[vec_idx];
    assign vec_state  = vst[vec_idx];
    assign vec_po_exp = vpo[vec_idx];
    assign vec_po_x   = vpox[vec_idx];
    assign vec_ns_exp = vns[vec_idx];
    assign vec_ns_x   = vnsx[vec_idx];

    always #10 clk = ~clk;

    scan_test_seq #(
        .PI_W(PI_W), .PO_W(PO_W), .NS(NS), .NCH(NCH), .VIDX_W(VIDX_W)
    ) dut_i (.*);

    typedef struct {
        logic [PO_W-1:0] po;
        logic            tc;
        logic            done;
        logic            fail;
        string           tag;
    } item_t;

    item_t q[$];
    int  n_chk  = 0;
    int  n_fail = 0;
    logic live  = 1'b0;

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    // circuit function from R2
    function automatic logic [NS-1:0] m_next(input logic [NS-1:0] s, input logic [PI_W-1:0] p);
        logic [NS-1:0] r;
        for (int i = 0; i < NS; i++) r[i] = s[(i + NS - 1) % NS] ^ p[i % PI_W];
        return r;
    endfunction

    function automatic logic [PO_W-1:0] m_po(input logic [NS-1:0] s, input logic [PI_W-1:0] p);
        logic [PO_W-1:0] r;
        for (int j = 0; j < PO_W; j++) r[j] = s[NS - 1 - j] ^ p[j];
        return r;
    endfunction

    // one shift of chain c per R3
    function automatic logic [NS-1:0] m_shift(input logic [NS-1:0] s, input int c, input logic b);
        int lc;
        lc = chain_len(NS, NCH, c);
        for (int j = 0; j < lc - 1; j++) s[c*SEG + j] = s[c*SEG + j + 1];
        s[c*SEG + lc - 1] = b;
        return s;
    endfunction

    task automatic prep(input int nc);
        for (int v = 0; v < 16; v++) begin
            vpi[v]  = PI_W'(5 + 3 * v);
            vst[v]  = NS'(22 ^ (7 * v));
            vns[v]  = m_next(vst[v], vpi[v]);
            vpo[v]  = m_po(vst[v], vpi[v]);
            vpox[v] = '0;
            vnsx[v] = '0;
        end
        if (nc < 0) vpi[0] = '0;
    endtask

    // driver side: expected per-cycle items
    task automatic build_q(input int nc, input bit exp_fail);
        logic [NS-1:0] s;
        item_t it;
        s = '0;
        for (int k = 0; k < SEG + 4; k++) begin
            it.po = '0; it.tc = 1'b0; it.done = 1'b0; it.fail = 1'b0; it.tag = "R4 flush";
            for (int c = 0; c < NCH; c++) it.po[c] = s[c*SEG];
            for (int c = 0; c < NCH; c++) s = m_shift(s, c, 1'((k >> 1) & 1));
            q.push_back(it);
        end
        for (int v = 0; v <= nc; v++) begin
            for (int k = 0; k < SEG; k++) begin
                it.po = '0; it.tc = 1'b0; it.done = 1'b0; it.fail = 1'b0;
                it.tag = (v == 0) ? "R5 load" : "R7 unload";
                for (int c = 0; c < NCH; c++) it.po[c] = s[c*SEG];
                for (int c = 0; c < NCH; c++) begin
                    int lc;
                    logic b;
                    lc = chain_len(NS, NCH, c);
                    b = 1'b0;
                    if (v < nc && k >= SEG - lc) b = vst[v][c*SEG + k - (SEG - lc)];
                    s = m_shift(s, c, b);
                end
                q.push_back(it);
            end
            if (v < nc) begin
                it.po = m_po(s, vpi[v]); it.tc = 1'b1; it.done = 1'b0; it.fail = 1'b0;
                it.tag = "R6 capture";
                s = m_next(s, vpi[v]);
                q.push_back(it);
            end
        end
        it.po = '0; it.tc = 1'b1; it.done = 1'b1; it.fail = exp_fail; it.tag = "R8 R9 done";
        q.push_back(it);
    endtask

    always @(posedge clk) begin
        if (start) live <= 1'b1;
        else if (q.size() == 0) live <= 1'b0;
    end

    // monitor: pop and compare
    always @(negedge clk) begin
        if (live && q.size() > 0) begin
            item_t it;
            bit ok;
            it = q.pop_front();
            ok = (test_ctl === it.tc) && (test_done === it.done);
            if (!it.done) ok = ok && (func_po === it.po);
            else          ok = ok && (test_fail === it.fail);
            check(ok, it.tag,
                  $sformatf("po=%b tc=%b done=%b fail=%b", func_po, test_ctl, test_done, test_fail),
                  $sformatf("po=%b tc=%b done=%b fail=%b", it.po, it.tc, it.done, it.fail));
        end
    end

    task automatic run(input int nc, input bit exp_fail, input bit poke);
        int n;
        int e;
        build_q(nc, exp_fail);
        n_vec = VIDX_W'(nc);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        n = 1;
        while (test_done !== 1'b1 && n < 1000) begin
            start = (poke && n == 3);   // R11: mid-run start must be ignored
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        e = (SEG + 4) + (SEG + 1) * nc + SEG + 1;
        check(n == e, (nc == 0) ? "R12 R8 length" : (poke ? "R11 R8 length" : "R8 length"),
              $sformatf("%0d", n), $sformatf("%0d", e));
        @(negedge clk);
        check(test_fail === exp_fail && test_ctl === 1'b1 && test_done === 1'b0,
              "R9 sticky after done",
              $sformatf("fail=%b tc=%b done=%b", test_fail, test_ctl, test_done),
              $sformatf("fail=%b tc=1 done=0", exp_fail));
        check(vec_idx === VIDX_W'(nc), "R10 final index",
              $sformatf("%0d", vec_idx), $sformatf("%0d", nc));
        while (live) @(negedge clk);
    endtask

    initial begin
        logic [NS-1:0] ms;
        logic [PI_W-1:0] p;
        prep(0);
        repeat (3) @(negedge clk);
        check(test_ctl === 1'b1 && test_done === 1'b0 && test_fail === 1'b0 && func_po === '0,
              "R1 reset", $sformatf("tc=%b done=%b fail=%b po=%b", test_ctl, test_done, test_fail, func_po),
              "tc=1 done=0 fail=0 po=000");
        rst = 1'b0;
        @(negedge clk);
        check(func_po === '0 && test_ctl === 1'b1, "R1 after reset",
              $sformatf("po=%b tc=%b", func_po, test_ctl), "po=000 tc=1");
        // R2 functional pass-through
        p = 4'b0110;
        func_pi = p;
        #1;
        ms = '0;
        check(func_po === m_po(ms, p), "R2 functional output",
              $sformatf("%b", func_po), $sformatf("%b", m_po(ms, p)));
        @(negedge clk);
        ms = m_next(ms, p);
        check(func_po === m_po(ms, p), "R2 functional next state",
              $sformatf("%b", func_po), $sformatf("%b", m_po(ms, p)));
        func_pi = '0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // correct vectors, with a stray start in mid-run
        prep(3);
        run(3, 1'b0, 1'b1);
        // no vectors
        prep(0);
        run(0, 1'b0, 1'b0);
        // corrupted next-state expectation: R7 compare must flag
        prep(2);
        vns[1][3] = ~vns[1][3];
        run(2, 1'b1, 1'b0);
        // same corruption masked: flag cleared at start, stays clear
        prep(2);
        vns[1][3]  = ~vns[1][3];
        vnsx[1][3] = 1'b1;
        run(2, 1'b0, 1'b0);
        // corrupted output expectation: R6 compare must flag
        prep(2);
        vpo[0][1] = ~vpo[0][1];
        run(2, 1'b1, 1'b0);
        // masked output corruption
        prep(2);
        vpo[0][1]  = ~vpo[0][1];
        vpox[0][1] = 1'b1;
        run(2, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule